// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the column address of every beat of an SDRAM read or write burst inside one open row. A controller gives it a start column, a burst-length code and a wrap-order select, then pulses a start strobe. From the next cycle on, the block presents one column per clock, with a valid flag and a flag that marks the final beat.

Finite bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of columns. The wrap is either sequential or interleaved. A full-page burst walks the whole 256-column page and keeps going round it until a terminate strobe arrives. A new start strobe always takes over at once and drops whatever is left of the running burst. The length and order are captured when a burst is accepted and held until it ends.

Top module: `col_burst_gen`

## Requirements
- R1: After reset, `valid_o` and `last_o` stay low until a start is accepted.
- R2: In sequential mode (`ilv_i` = 0) with `bl_code_i[2]` = 0, the burst length is BL = 2^`bl_code_i[1:0]`, giving 1, 2, 4 or 8. `valid_o` is high for BL cycles, starting in the cycle after the start is sampled. On beat k, `col_o` keeps the bits of the start column above bit log2(BL). Its low log2(BL) bits equal (start low bits + k) mod BL.
- R3: In interleaved mode (`ilv_i` = 1) with a finite length, beat k presents the start column with its low log2(BL) bits XORed with k.
- R4: In a finite burst, `last_o` is high on beat BL-1 only. `valid_o` is low in the next cycle unless a new start was sampled.
- R5: With `bl_code_i[2]` = 1 and `ilv_i` = 0 (full page), beat k presents (start + k) mod 256, wrapping round the page. The burst runs until `stop_i` is sampled. `last_o` is high only in a valid cycle where `stop_i` is high, and `valid_o` is low after it.
- R6: A start that asks for full page with `ilv_i` = 1 is ignored: no burst begins, and a burst already running carries on unchanged.
- R7: An accepted start during a burst makes the next cycle beat 0 of the new burst. The old burst's remaining beats are dropped. A start has priority over `stop_i` at the same edge.
- R8: The length code and wrap select are sampled only when a start is accepted. Changing them during a burst has no effect on its addresses or length.
- R9: `stop_i` high in a valid cycle of a finite burst raises `last_o` in that cycle and ends the burst after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a burst at this edge |
| start_col_i | input | 8 | Start column |
| bl_code_i | input | 3 | Length code: bit 2 set means full page, else BL = 2^[1:0] |
| ilv_i | input | 1 | 1 = interleaved wrap order, 0 = sequential |
| stop_i | input | 1 | Terminate the running burst this cycle |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | This beat is the final one |

## Verification
The hardest cases to reach are the ones where several strobes meet a running burst. A start can land in the middle of a burst, a stop can arrive in the same cycle as a start, or the configuration inputs can change while a burst is still running. The stimulus is driven one cycle at a time. It sets up each collision on a chosen beat and also pushes the column expected for that cycle, so the exact cycle of each takeover is checked. A full-page burst is started close to the top of the page so that it wraps through column 0 before the stop is given.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

  localparam int unsigned PAGE_COL_W = 8;
  localparam int unsigned LG_W       = 2;

  typedef logic [PAGE_COL_W-1:0] col_t;

  typedef struct packed {
    col_t            base;
    logic [LG_W-1:0] lg;
    logic            ilv;
    logic            full;
  } burst_cfg_t;

  function automatic col_t wrap_mask(logic [LG_W-1:0] lg);
    return col_t'((1 << lg) - 1);
  endfunction

  function automatic col_t beat_col(burst_cfg_t cfg, col_t beat);
    col_t mask;
    col_t low;
    if (cfg.full) return cfg.base + beat;
    mask = wrap_mask(cfg.lg);
    if (cfg.ilv) low = (cfg.base ^ beat) & mask;
    else         low = (cfg.base + beat) & mask;
    return (cfg.base & ~mask) | low;
  endfunction

endpackage

// File: rtl/cbg_cfg_latch.sv
module cbg_cfg_latch
  import col_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  burst_cfg_t cfg_in,
  output burst_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (take) cfg_q <= cfg_in;
  end

  // R8: configuration changes only when a start is accepted
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cfg_q));

endmodule

// File: rtl/cbg_beat_ctr.sv
module cbg_beat_ctr
  import col_burst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            last,
  input  logic            full,
  input  logic [LG_W-1:0] lg,
  output logic            active,
  output col_t            beat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (take) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      beat   <= beat + col_t'(1);
    end
  end

  // R2: a finite burst never passes beat BL-1
  a_r2_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !full) |-> (beat <= wrap_mask(lg)));

  // R7: an accepted start yields beat 0 next cycle
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (active && beat == '0));

  // R4: the burst ends after its final beat
  a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last && !take) |=> !active);

endmodule

// File: rtl/cbg_addr_map.sv
module cbg_addr_map
  import col_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  burst_cfg_t cfg,
  input  col_t       beat,
  output col_t       col
);

  assign col = beat_col(cfg, beat);

  // R2: finite bursts never leave their aligned block
  a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cfg.full) |->
      ((col & ~wrap_mask(cfg.lg)) == (cfg.base & ~wrap_mask(cfg.lg))));

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
  import col_burst_pkg::*;
#(
  parameter int unsigned COL_W = PAGE_COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  burst_cfg_t cfg_in_w;
  burst_cfg_t cfg_q_w;
  col_t       beat_w;
  logic       active_w;
  logic       illegal_w;
  logic       take_w;
  logic       final_beat_w;
  logic       last_w;

  assign illegal_w    = ilv_i && bl_code_i[2];
  assign take_w       = start_i && !illegal_w;
  assign cfg_in_w     = '{base: start_col_i, lg: bl_code_i[LG_W-1:0],
                          ilv: ilv_i, full: bl_code_i[2]};
  assign final_beat_w = !cfg_q_w.full && (beat_w == wrap_mask(cfg_q_w.lg));
  assign last_w       = active_w && (stop_i || final_beat_w);

  cbg_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .take(take_w),
    .cfg_in(cfg_in_w), .cfg_q(cfg_q_w)
  );

  cbg_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .take(take_w), .last(last_w),
    .full(cfg_q_w.full), .lg(cfg_q_w.lg),
    .active(active_w), .beat(beat_w)
  );

  cbg_addr_map u_map (
    .clk(clk), .rst_n(rst_n), .active(active_w),
    .cfg(cfg_q_w), .beat(beat_w), .col(col_o)
  );

  assign valid_o = active_w;
  assign last_o  = last_w;

  // R6: an illegal request starts nothing from idle
  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && illegal_w && !valid_o) |=> !valid_o);

  // R5: full page only ends on a stop
  a_r5_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_q_w.full && !stop_i) |-> !last_o);

  // R1: last only with valid
  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

endmodule

// File: tb/test_col_burst_gen.sv
module test_col_burst_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  always #10 clk = ~clk;

  col_burst_gen i_col_burst_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  typedef struct {
    logic       v;
    logic [7:0] c;
    logic       l;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // reference model state
  bit       m_act = 0;
  int       m_beat = 0;
  int       m_scol = 0;
  int       m_len = 1;
  bit       m_ilv = 0;
  bit       m_full = 0;

  function automatic int model_col();
    int off;
    int base;
    if (m_full) return (m_scol + m_beat) % 256;
    off  = m_scol % m_len;
    base = m_scol - off;
    if (m_ilv) return base + (off ^ m_beat);
    return base + ((off + m_beat) % m_len);
  endfunction

  task automatic step(input bit s, input int scol, input int code,
                      input bit ilv, input bit stp, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    start_i = s; start_col_i = 8'(scol); bl_code_i = 3'(code);
    ilv_i = ilv; stop_i = stp;
    e.v   = m_act;
    e.c   = m_act ? 8'(model_col()) : 8'h00;
    e.l   = m_act && (stp || (!m_full && m_beat == m_len - 1));
    e.tag = tag;
    exp_q.push_back(e);
    if (s && !(ilv && code >= 4)) begin
      m_act = 1; m_beat = 0; m_scol = scol; m_ilv = ilv;
      m_full = (code >= 4); m_len = 1 << (code % 4);
    end else if (m_act) begin
      if (e.l) m_act = 0;
      else m_beat = (m_beat + 1) % 256;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_run++;
        if (valid_o !== e.v || last_o !== e.l || (e.v && col_o !== e.c)) begin
          n_fail++;
          $display("FAIL %s: got v=%0b col=%02h last=%0b, expected v=%0b col=%02h last=%0b",
                   e.tag, valid_o, col_o, last_o, e.v, e.c, e.l);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3, "R1 reset idle");
    // R1: stop alone does nothing from idle
    step(0, 0, 0, 0, 1, "R1 stop idle");
    idle(1, "R1 reset idle");
    // R2 sequential BL4 from 0x3E, R4 last
    step(1, 8'h3E, 2, 0, 0, "R2 seq BL4");
    idle(5, "R2 R4 seq BL4");
    // R2 sequential BL8 and BL2
    step(1, 8'h45, 3, 0, 0, "R2 seq BL8");
    idle(9, "R2 seq BL8");
    step(1, 8'h81, 1, 0, 0, "R2 seq BL2");
    idle(3, "R2 seq BL2");
    // R4 single beat
    step(1, 8'h7B, 0, 0, 0, "R4 BL1");
    idle(2, "R4 BL1");
    // R3 interleaved BL8 and BL4
    step(1, 8'h15, 3, 1, 0, "R3 ilv BL8");
    idle(9, "R3 ilv BL8");
    step(1, 8'hC6, 2, 1, 0, "R3 ilv BL4");
    idle(5, "R3 ilv BL4");
    // R5 full page across the page top
    step(1, 8'hFD, 4, 0, 0, "R5 full page");
    idle(6, "R5 full page wrap");
    step(0, 0, 0, 0, 1, "R5 full page stop");
    idle(2, "R5 after stop");
    // R6 illegal request from idle and during a burst
    step(1, 8'h20, 4, 1, 0, "R6 reject idle");
    idle(2, "R6 reject idle");
    step(1, 8'h30, 2, 0, 0, "R6 burst");
    idle(1, "R6 burst");
    step(1, 8'h90, 7, 1, 0, "R6 reject running");
    idle(4, "R6 burst continues");
    // R7 takeover mid-burst, and start beats stop at the same edge
    step(1, 8'h50, 3, 0, 0, "R7 first");
    idle(2, "R7 first");
    step(1, 8'hA2, 2, 1, 0, "R7 takeover");
    idle(1, "R7 new burst");
    step(1, 8'h10, 1, 0, 1, "R7 start with stop");
    idle(3, "R7 after");
    // R8 config changes mid-burst ignored
    step(1, 8'h64, 3, 0, 0, "R8 start");
    step(0, 8'hFF, 0, 1, 0, "R8 cfg change");
    step(0, 8'h00, 4, 1, 0, "R8 cfg change");
    idle(7, "R8 unchanged");
    // R9 stop ends a finite burst early
    step(1, 8'hE8, 3, 0, 0, "R9 start");
    idle(2, "R9 run");
    step(0, 0, 0, 0, 1, "R9 stop");
    idle(2, "R9 ended");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule